// File: doc/BRIEF.md
# I2S Master Bit Clock and Word-Select Generator

This block produces the serial bit clock, the left/right word-select line and the half-frame timing strobes for the master side of an I2S controller. The bit clock is derived from the system clock by a programmable divider: each high and each low phase of the bit clock lasts a programmed number of system clocks. The word-select line changes after a selectable number of bit clocks (16, 24 or 32 slots per channel), so one frame spans twice that many bit clocks. The bit clock rate is therefore the sample rate times the slot width times two.

Two nested enables govern the block. The global enable must be high before anything can run, and dropping it stops everything at the next clock edge. The clock enable, asserted last during start-up, starts the bit clock with word-select low (the left channel). When the clock enable is cleared while the global enable stays high, the current bit finishes, so the bit clock never produces a shortened pulse. The slot code and the divider are captured when the clocks start and hold for the whole run.

Top module: `i2s_ws_clkgen`

## Requirements
- R1: After reset, bclk_o, ws_o, bit_stb_o, left_stb_o, right_stb_o and running_o are all low.
- R2: slot_code_i selects the bit clocks per word-select half: 0 gives 16, 1 gives 24, 2 and 3 give 32. Between a left strobe and the next right strobe there are exactly that many bit-clock rising edges.
- R3: Each bit-clock high phase and low phase lasts H system clocks, with H = half_div_i and a value of 0 treated as 1. A word-select half therefore lasts 2·H·slots system clocks.
- R4: While glb_en_i is low, running_o and bclk_o stay low whatever clk_en_i does.
- R5: When glb_en_i and clk_en_i are high while idle, the next cycle shows running_o high, bclk_o low, ws_o low and left_stb_o high.
- R6: ws_o changes only in a cycle where bclk_o has just fallen. right_stb_o pulses in the cycle ws_o becomes 1, and left_stb_o pulses in the cycle ws_o becomes 0. The two strobes are never high together. bit_stb_o pulses in each cycle in which bclk_o has just fallen.
- R7: Clearing clk_en_i with glb_en_i high lets the current bit finish. running_o drops in the same cycle that bclk_o falls, ws_o returns low in that cycle, and no bit-clock high phase is shorter than H.
- R8: Clearing glb_en_i forces every output low in the next cycle, even in the middle of a bit.
- R9: slot_code_i and half_div_i are captured at start. Changing them while running has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global enable of the controller |
| clk_en_i | input | 1 | Clock enable: starts and gracefully stops the clocks |
| slot_code_i | input | 2 | Slot-width code (bit clocks per word-select half) |
| half_div_i | input | DIV_W | System clocks per bit-clock phase (0 acts as 1) |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, 0 = left, 1 = right |
| bit_stb_o | output | 1 | One-cycle pulse when the bit clock has just fallen |
| left_stb_o | output | 1 | One-cycle pulse at the start of a left half |
| right_stb_o | output | 1 | One-cycle pulse at the start of a right half |
| running_o | output | 1 | Clocks are active |

## Verification
The graceful stop and the word-select boundary both act on a falling edge of the bit clock, so they can land in the same cycle. The bench clears the clock enable in the cycle right after a left strobe. It also clears it right after a full frame, where the pending stop meets the first bit boundary of the next half. It judges the result by the stop latency of exactly 2·H cycles, by bclk_o and ws_o being low in the cycle running_o drops, and by no shortened high phase. A second collision, a global clear during a running bit, must win over any divider tick in that cycle, and the bench checks that every output is low one cycle later.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

    localparam int SLOT_W = 6;

    // Slot-width code to bit clocks per word-select half.
    function automatic logic [SLOT_W-1:0] slot_bits(input logic [1:0] code);
        logic [SLOT_W-1:0] n;
        case (code)
            2'd0:    n = SLOT_W'(16);
            2'd1:    n = SLOT_W'(24);
            default: n = SLOT_W'(32);
        endcase
        return n;
    endfunction

    typedef struct packed {
        logic              bclk;
        logic              ws;
        logic [SLOT_W-1:0] bit_cnt;
        logic              l_stb;
        logic              r_stb;
        logic              b_stb;
    } seq_t;

endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == half_i - DIV_W'(1));

    always_comb begin
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq
    import i2s_clkgen_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              kill_i,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              halt_i,
    input  logic [SLOT_W-1:0] slots_i,
    output logic              fall_evt_o,
    output logic              bclk_o,
    output logic              ws_o,
    output logic              bit_stb_o,
    output logic              left_stb_o,
    output logic              right_stb_o
);

    seq_t s_d, s_q;

    assign fall_evt_o = tick_i && s_q.bclk;

    always_comb begin
        s_d       = s_q;
        s_d.l_stb = 1'b0;
        s_d.r_stb = 1'b0;
        s_d.b_stb = 1'b0;
        if (kill_i) begin
            s_d = '0;
        end else if (start_i) begin
            s_d       = '0;
            s_d.l_stb = 1'b1;
        end else if (tick_i) begin
            if (!s_q.bclk) begin
                s_d.bclk = 1'b1;
            end else begin
                s_d.bclk  = 1'b0;
                s_d.b_stb = 1'b1;
                if (halt_i) begin
                    s_d.ws      = 1'b0;
                    s_d.bit_cnt = '0;
                end else if (s_q.bit_cnt == slots_i - SLOT_W'(1)) begin
                    s_d.bit_cnt = '0;
                    s_d.ws      = ~s_q.ws;
                    s_d.l_stb   = s_q.ws;
                    s_d.r_stb   = ~s_q.ws;
                end else begin
                    s_d.bit_cnt = s_q.bit_cnt + SLOT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bclk_o      = s_q.bclk;
    assign ws_o        = s_q.ws;
    assign bit_stb_o   = s_q.b_stb;
    assign left_stb_o  = s_q.l_stb;
    assign right_stb_o = s_q.r_stb;

endmodule

// File: rtl/i2s_ws_clkgen.sv
module i2s_ws_clkgen
    import i2s_clkgen_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             glb_en_i,
    input  logic             clk_en_i,
    input  logic [1:0]       slot_code_i,
    input  logic [DIV_W-1:0] half_div_i,
    output logic             bclk_o,
    output logic             ws_o,
    output logic             bit_stb_o,
    output logic             left_stb_o,
    output logic             right_stb_o,
    output logic             running_o
);

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slots;
        logic [DIV_W-1:0]  half;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  start;
    logic  tick;
    logic  fall_evt;

    assign start = glb_en_i && clk_en_i && !c_q.active;

    always_comb begin
        c_d = c_q;
        if (!glb_en_i) begin
            c_d.active = 1'b0;
        end else if (start) begin
            c_d.active = 1'b1;
            c_d.slots  = slot_bits(slot_code_i);
            c_d.half   = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
        end else if (fall_evt && !clk_en_i) begin
            c_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q        <= '0;
            c_q.slots  <= SLOT_W'(16);
            c_q.half   <= DIV_W'(1);
        end else begin
            c_q <= c_d;
        end
    end

    i2s_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (c_q.active),
        .half_i (c_q.half),
        .tick_o (tick)
    );

    i2s_frame_seq u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .kill_i      (!glb_en_i),
        .start_i     (start),
        .tick_i      (tick),
        .halt_i      (!clk_en_i),
        .slots_i     (c_q.slots),
        .fall_evt_o  (fall_evt),
        .bclk_o      (bclk_o),
        .ws_o        (ws_o),
        .bit_stb_o   (bit_stb_o),
        .left_stb_o  (left_stb_o),
        .right_stb_o (right_stb_o)
    );

    assign running_o = c_q.active;

endmodule

// File: rtl/i2s_ws_clkgen_chk.sv
module i2s_ws_clkgen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic glb_en_i,
    input logic clk_en_i,
    input logic bclk_o,
    input logic ws_o,
    input logic bit_stb_o,
    input logic left_stb_o,
    input logic right_stb_o,
    input logic running_o
);

    assert_idle_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !glb_en_i |=> (!bclk_o && !running_o));

    assert_global_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !glb_en_i |=> (!ws_o && !bit_stb_o && !left_stb_o && !right_stb_o));

    assert_start_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(running_o) |-> ($past(glb_en_i && clk_en_i) && !bclk_o && !ws_o && left_stb_o));

    assert_strobes_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({left_stb_o, right_stb_o}));

    assert_ws_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($changed(ws_o) && $past(glb_en_i)) |-> $fell(bclk_o));

    assert_side_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (right_stb_o |-> ws_o) and (left_stb_o |-> !ws_o));

    assert_bit_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_stb_o |-> !bclk_o);

    assert_graceful_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(running_o) && $past(glb_en_i)) |-> ($fell(bclk_o) && !ws_o && $past(!clk_en_i)));

endmodule

bind i2s_ws_clkgen i2s_ws_clkgen_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .glb_en_i    (glb_en_i),
    .clk_en_i    (clk_en_i),
    .bclk_o      (bclk_o),
    .ws_o        (ws_o),
    .bit_stb_o   (bit_stb_o),
    .left_stb_o  (left_stb_o),
    .right_stb_o (right_stb_o),
    .running_o   (running_o)
);

// File: tb/tb_i2s_ws_clkgen.sv
module tb_i2s_ws_clkgen;

    localparam int DIV_W = 8;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             glb_en_i = 1'b0;
    logic             clk_en_i = 1'b0;
    logic [1:0]       slot_code_i = 2'd0;
    logic [DIV_W-1:0] half_div_i = 8'd1;
    logic bclk_o, ws_o, bit_stb_o, left_stb_o, right_stb_o, running_o;

    int total = 0;
    int bad   = 0;
    int mon_half = 1;
    bit mon_en = 1'b0;
    int hi_run = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    i2s_ws_clkgen #(.DIV_W(DIV_W)) dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .clk_en_i(clk_en_i),
        .slot_code_i(slot_code_i), .half_div_i(half_div_i),
        .bclk_o(bclk_o), .ws_o(ws_o), .bit_stb_o(bit_stb_o),
        .left_stb_o(left_stb_o), .right_stb_o(right_stb_o), .running_o(running_o)
    );

    typedef struct packed {
        logic [1:0] code;
        logic [7:0] div;
        logic [7:0] slots;
        logic [7:0] half;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'd1, 8'd16, 8'd1},
        '{2'd1, 8'd1, 8'd24, 8'd1},
        '{2'd2, 8'd1, 8'd32, 8'd1},
        '{2'd3, 8'd2, 8'd32, 8'd2},
        '{2'd0, 8'd0, 8'd16, 8'd1},
        '{2'd1, 8'd3, 8'd24, 8'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3: every high phase of the bit clock lasts exactly H system clocks
    always @(negedge clk_i) begin
        if (mon_en) begin
            if (bclk_o) begin
                hi_run++;
            end else if (hi_run != 0) begin
                chk(hi_run == mon_half, "R3 high phase width", hi_run, mon_half);
                hi_run = 0;
            end
        end else begin
            hi_run = 0;
        end
    end

    // count cycles and rising edges until the given strobe appears
    task automatic measure(input bit want_right, output int cyc, output int rises);
        logic prev;
        prev  = bclk_o;
        cyc   = 0;
        rises = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk_i);
            cyc++;
            if (bclk_o && !prev) rises++;
            prev = bclk_o;
            if (want_right ? right_stb_o : left_stb_o) break;
        end
    endtask

    task automatic start_clk(input logic [1:0] code, input logic [7:0] div);
        @(negedge clk_i);
        glb_en_i    = 1'b1;
        slot_code_i = code;
        half_div_i  = div;
        @(negedge clk_i);
        clk_en_i = 1'b1;
        @(negedge clk_i);
    endtask

    task automatic stop_and_check(input int h);
        int lat;
        logic prev;
        clk_en_i = 1'b0;
        lat  = 0;
        prev = bclk_o;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk_i);
            lat++;
            if (!running_o) break;
            prev = bclk_o;
        end
        chk(lat == 2 * h, "R7 stop latency", lat, 2 * h);
        chk(prev && !bclk_o && !ws_o, "R7 stop on falling edge, ws low",
            {prev, bclk_o, ws_o}, 3'b100);
        chk(bit_stb_o, "R6 bit strobe at stop fall", bit_stb_o, 1);
        repeat (4) @(negedge clk_i);
        chk(!running_o && !bclk_o, "R7 stays idle", running_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cyc, rises;
        // R1: reset state
        repeat (3) @(negedge clk_i);
        chk({bclk_o, ws_o, bit_stb_o, left_stb_o, right_stb_o, running_o} == 6'b0,
            "R1 outputs in reset", 0, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        chk({bclk_o, ws_o, bit_stb_o, left_stb_o, right_stb_o, running_o} == 6'b0,
            "R1 outputs after reset",
            {bclk_o, ws_o, bit_stb_o, left_stb_o, right_stb_o, running_o}, 0);

        // vector walk: R2, R3, R5, R6, R7
        foreach (VECS[i]) begin
            mon_half = int'(VECS[i].half);
            mon_en   = 1'b1;
            start_clk(VECS[i].code, VECS[i].div);
            chk(running_o && left_stb_o && !ws_o && !bclk_o, "R5 start state",
                {running_o, left_stb_o, ws_o, bclk_o}, 4'b1100);
            measure(1'b1, cyc, rises);
            chk(cyc == 2 * int'(VECS[i].half) * int'(VECS[i].slots),
                "R3 left half length", cyc, 2 * int'(VECS[i].half) * int'(VECS[i].slots));
            chk(rises == int'(VECS[i].slots), "R2 bit clocks per half", rises, int'(VECS[i].slots));
            chk(ws_o && !left_stb_o, "R6 right strobe with ws high", ws_o, 1);
            measure(1'b0, cyc, rises);
            chk(cyc == 2 * int'(VECS[i].half) * int'(VECS[i].slots),
                "R3 right half length", cyc, 2 * int'(VECS[i].half) * int'(VECS[i].slots));
            chk(!ws_o && !right_stb_o, "R6 left strobe with ws low", ws_o, 0);
            stop_and_check(int'(VECS[i].half));
            mon_en = 1'b0;
        end

        // R7: stop requested right after start, collides with first bit end
        mon_half = 3;
        mon_en   = 1'b1;
        start_clk(2'd0, 8'd3);
        stop_and_check(3);
        mon_en = 1'b0;

        // R4: global enable low blocks the clock enable
        @(negedge clk_i);
        glb_en_i = 1'b0;
        clk_en_i = 1'b1;
        begin
            bit seen;
            seen = 1'b0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk_i);
                if (running_o || bclk_o || left_stb_o) seen = 1'b1;
            end
            chk(!seen, "R4 no activity without global enable", seen, 0);
        end
        clk_en_i = 1'b0;

        // R9: configuration changes while running are ignored
        mon_half = 1;
        mon_en   = 1'b1;
        start_clk(2'd0, 8'd1);
        slot_code_i = 2'd2;
        half_div_i  = 8'd3;
        measure(1'b1, cyc, rises);
        chk(cyc == 32, "R9 half length keeps captured config", cyc, 32);
        chk(rises == 16, "R9 slot count keeps captured config", rises, 16);
        stop_and_check(1);
        mon_en = 1'b0;

        // R8: global clear in the middle of a bit
        start_clk(2'd1, 8'd2);
        repeat (7) @(negedge clk_i);
        glb_en_i = 1'b0;
        @(negedge clk_i);
        chk({bclk_o, ws_o, bit_stb_o, left_stb_o, right_stb_o, running_o} == 6'b0,
            "R8 immediate global stop",
            {bclk_o, ws_o, bit_stb_o, left_stb_o, right_stb_o, running_o}, 0);
        clk_en_i = 1'b0;
        repeat (3) @(negedge clk_i);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule